// File: doc/BRIEF.md
# SPI Master with Atomic Register Aliases

This block is a memory-mapped SPI master. Software sees four word registers: configuration, status, data and clock divider. Each register answers at four word addresses. The alias address decides how a write combines with the stored value: replace it, clear bits, set bits, or toggle bits. This lets software change single bits without a read-modify-write sequence.

A write to the data register starts a full-duplex exchange of one, two or four bytes, most significant bit first, in SPI mode 0. The bits that come back on the serial input are packed into a word. Received words go to one of two places, chosen by the configuration:

- a single holding slot, or
- a four-entry circular ring with read and write pointers.

Full and overflow flags track the state of whichever is in use. Three sticky interrupt lines report three events: an exchange finished, received data is waiting, and data arrived while the receive side was still full.

Top module: `spi_alias_ctrl`

## Requirements
- R1: The bus address is a word address. Bits [3:2] select the register: 0 configuration, 1 status, 2 data, 3 clock divider. Word addresses 16 and above read as zero and ignore writes.
- R2: Address bits [1:0] select how a write to the configuration or divider register is applied: 0 replaces the value, 1 clears the bits set in the write data, 2 sets them, 3 toggles them.
- R3: Status bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is overflow, bit 3 is busy. Only bit 2 accepts writes, with the same four alias operations. The other bits keep their values.
- R4: Configuration bit 0 enables the block, bit 1 selects 16-bit words, bit 2 selects 32-bit words, bit 3 selects the ring. Other bits read zero. A configuration write that leaves bit 0 clear does three things: it lowers all three interrupt lines, it stops any exchange in progress, and it makes status read 0x2.
- R5: A configuration write that leaves the enable bit set and the ring bit clear returns both ring pointers to entry 0.
- R6: An exchange moves 32 bits when bit 2 is set, else 16 bits when bit 1 is set, else 8 bits. It shifts out the low bits of the written word, most significant first. The received bits land in the same low positions, and the upper bits are zero.
- R7: SCK idles low. MOSI changes on falling edges and MISO is sampled on rising edges. Each SCK half period lasts divider+1 clock cycles, so an exchange of N bits stays busy for 2·N·(divider+1) cycles.
- R8: During an exchange, busy is 1 and transmit-empty is 0. A data write is ignored while busy or while the block is disabled.
- R9: Reading the data register returns the entry at the read pointer and clears receive-full. In single-slot mode every finished exchange sets receive-full.
- R10: In ring mode, a finished exchange advances the write pointer modulo 4 and sets receive-full when it lands on the read pointer. A data read advances the read pointer modulo 4.
- R11: If receive-full is still set when an exchange finishes, the new word overwrites the entry at the write pointer, overflow is set, and neither pointer moves.
- R12: Every finished exchange sets the transmit interrupt. An exchange that sets receive-full raises the receive interrupt, and an overflow raises the fault interrupt. All three stay high until a configuration write clears the enable bit.
- R13: After reset, configuration and divider read zero, status reads 0x2, and the interrupt lines and SCK are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (read side effects) |
| busAddr | input | 6 | Word address: window, register, alias |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irqFault | output | 1 | Sticky overflow interrupt |
| irqTx | output | 1 | Sticky exchange-done interrupt |
| irqRx | output | 1 | Sticky receive-ready interrupt |

## Verification
The hardest state to reach from the ports is a ring whose write pointer has wrapped onto the read pointer, followed by a fifth exchange that overflows. The stimulus fills the ring with four exchanges and no reads, runs a fifth exchange, and then drains the ring. The first word read back must be the newest word, because the overflow overwrote the oldest entry.

A second hard case is a pointer reset while the pointers are apart. It is set up by running two ring exchanges and one read, then switching to single-slot mode. The next read must return the fresh word from entry 0, not the stale word at the old read pointer.

// File: rtl/spi_alias_pkg.sv
package spi_alias_pkg;

  typedef enum logic [1:0] {
    OP_ASSIGN = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_INVERT = 2'd3
  } aliasOp_e;

  typedef enum logic [1:0] {
    SLOT_CFG  = 2'd0,
    SLOT_STAT = 2'd1,
    SLOT_DATA = 2'd2,
    SLOT_DIV  = 2'd3
  } slot_e;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 6;
  localparam int CFG_W  = 4;

  // configuration bit positions
  localparam int CFG_EN   = 0;
  localparam int CFG_W16  = 1;
  localparam int CFG_W32  = 2;
  localparam int CFG_RING = 3;

  // status bit positions
  localparam int ST_FULL  = 0;
  localparam int ST_TXE   = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_BUSY  = 3;

  typedef struct packed {
    logic              start;
    logic              abort;
    logic [CNT_W-1:0]  nBits;
    logic [WORD_W-1:0] txWord;
  } dpCmd_t;

endpackage

// File: rtl/spi_alias_shifter.sv
module spi_alias_shifter
  import spi_alias_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [DIV_W-1:0]    divider,
  input  logic                miso,
  output logic                sck,
  output logic                mosi,
  output logic                busy,
  output logic                done,
  output logic [WORD_W-1:0]   rxWord
);

  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  nBitsR;
  logic              sckR;
  logic              busyR;
  logic              divHit;
  logic              lastFall;

  assign divHit   = (divCnt >= divider);
  assign lastFall = busyR && divHit && sckR && (bitCnt == nBitsR - CNT_W'(1));
  assign done     = lastFall && !cmd.abort;
  assign sck      = sckR;
  assign busy     = busyR;
  assign mosi     = txShift[WORD_W-1];
  assign rxWord   = rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      nBitsR  <= '0;
      sckR    <= 1'b0;
      busyR   <= 1'b0;
    end else if (cmd.abort) begin
      busyR  <= 1'b0;
      sckR   <= 1'b0;
      divCnt <= '0;
    end else if (cmd.start && !busyR) begin
      busyR   <= 1'b1;
      sckR    <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      nBitsR  <= cmd.nBits;
      rxShift <= '0;
      txShift <= cmd.txWord << (CNT_W'(WORD_W) - cmd.nBits);
    end else if (busyR) begin
      if (divHit) begin
        divCnt <= '0;
        if (!sckR) begin
          sckR    <= 1'b1;
          rxShift <= {rxShift[WORD_W-2:0], miso};
        end else begin
          sckR    <= 1'b0;
          txShift <= {txShift[WORD_W-2:0], 1'b0};
          bitCnt  <= bitCnt + CNT_W'(1);
          if (lastFall) busyR <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // R7: clock is parked low whenever no exchange runs
  a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  // R8: the final falling edge ends the busy phase
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8: busy only rises after an accepted start strobe
  a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmd.start));

endmodule

// File: rtl/spi_alias_regs.sv
module spi_alias_regs
  import spi_alias_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RING_DEPTH = 4,
  parameter int ADDR_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  busRdata,
  input  logic               dpBusy,
  input  logic               dpDone,
  input  logic [WORD_W-1:0]  dpRxWord,
  output dpCmd_t             cmd,
  output logic [DIV_W-1:0]   divider,
  output logic               irqFault,
  output logic               irqTx,
  output logic               irqRx
);

  localparam int PTR_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(RING_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [CFG_W-1:0]  cfgBits;
  logic [DIV_W-1:0]  divReg;
  logic              rxFull, rxOvf;
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [WORD_W-1:0] ring [RING_DEPTH];
  logic              irqF, irqT, irqR;

  logic              inWindow;
  slot_e             slot;
  aliasOp_e          op;
  logic              wrCfg, wrStat, wrData, wrDiv, rdData;
  logic [CFG_W-1:0]  cfgNew;
  logic [DIV_W-1:0]  divNew;
  logic              ovfAlias;
  logic              goingOff, ptrClr, ringOn;
  logic              fullN, ovfN, ovfEvent, fillEvent, fullAfterRead;
  logic [PTR_W-1:0]  rdN, wrN;
  logic [3:0]        statWord;

  assign inWindow = (busAddr[ADDR_W-1:4] == '0);
  assign slot     = slot_e'(busAddr[3:2]);
  assign op       = aliasOp_e'(busAddr[1:0]);
  assign wrCfg    = busWe && inWindow && (slot == SLOT_CFG);
  assign wrStat   = busWe && inWindow && (slot == SLOT_STAT);
  assign wrData   = busWe && inWindow && (slot == SLOT_DATA);
  assign wrDiv    = busWe && inWindow && (slot == SLOT_DIV);
  assign rdData   = busRe && inWindow && (slot == SLOT_DATA);
  assign ringOn   = cfgBits[CFG_RING];

  always_comb begin
    unique case (op)
      OP_ASSIGN: cfgNew = busWdata[CFG_W-1:0];
      OP_CLEAR:  cfgNew = cfgBits & ~busWdata[CFG_W-1:0];
      OP_SET:    cfgNew = cfgBits | busWdata[CFG_W-1:0];
      default:   cfgNew = cfgBits ^ busWdata[CFG_W-1:0];
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ASSIGN: divNew = busWdata[DIV_W-1:0];
      OP_CLEAR:  divNew = divReg & ~busWdata[DIV_W-1:0];
      OP_SET:    divNew = divReg | busWdata[DIV_W-1:0];
      default:   divNew = divReg ^ busWdata[DIV_W-1:0];
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ASSIGN: ovfAlias = busWdata[ST_OVF];
      OP_CLEAR:  ovfAlias = rxOvf & ~busWdata[ST_OVF];
      OP_SET:    ovfAlias = rxOvf | busWdata[ST_OVF];
      default:   ovfAlias = rxOvf ^ busWdata[ST_OVF];
    endcase
  end

  assign goingOff = wrCfg && !cfgNew[CFG_EN];
  assign ptrClr   = wrCfg && cfgNew[CFG_EN] && !cfgNew[CFG_RING];

  // strobes toward the shift engine
  always_comb begin
    cmd.start  = wrData && cfgBits[CFG_EN] && !dpBusy;
    cmd.abort  = goingOff;
    cmd.txWord = busWdata;
    if (cfgBits[CFG_W32])      cmd.nBits = CNT_W'(32);
    else if (cfgBits[CFG_W16]) cmd.nBits = CNT_W'(16);
    else                       cmd.nBits = CNT_W'(8);
  end

  assign fullAfterRead = rdData ? 1'b0 : rxFull;

  always_comb begin
    fullN     = fullAfterRead;
    ovfN      = wrStat ? ovfAlias : rxOvf;
    rdN       = (rdData && ringOn) ? stepPtr(rdPtr) : rdPtr;
    wrN       = wrPtr;
    ovfEvent  = 1'b0;
    fillEvent = 1'b0;
    if (dpDone) begin
      if (fullAfterRead) begin
        ovfN     = 1'b1;
        ovfEvent = 1'b1;
      end else if (ringOn) begin
        wrN = stepPtr(wrPtr);
        if (wrN == rdN) begin
          fullN     = 1'b1;
          fillEvent = 1'b1;
        end
      end else begin
        fullN     = 1'b1;
        fillEvent = 1'b1;
      end
    end
    if (goingOff) begin
      fullN = 1'b0;
      ovfN  = 1'b0;
    end
    if (ptrClr) begin
      rdN = '0;
      wrN = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
      divReg  <= '0;
      rxFull  <= 1'b0;
      rxOvf   <= 1'b0;
      rdPtr   <= '0;
      wrPtr   <= '0;
      irqF    <= 1'b0;
      irqT    <= 1'b0;
      irqR    <= 1'b0;
      for (int i = 0; i < RING_DEPTH; i++) ring[i] <= '0;
    end else begin
      if (wrCfg) cfgBits <= cfgNew;
      if (wrDiv) divReg  <= divNew;
      rxFull <= fullN;
      rxOvf  <= ovfN;
      rdPtr  <= rdN;
      wrPtr  <= wrN;
      if (dpDone) ring[wrPtr] <= dpRxWord;
      if (goingOff) begin
        irqF <= 1'b0;
        irqT <= 1'b0;
        irqR <= 1'b0;
      end else begin
        if (dpDone)    irqT <= 1'b1;
        if (fillEvent) irqR <= 1'b1;
        if (ovfEvent)  irqF <= 1'b1;
      end
    end
  end

  assign statWord = {dpBusy, rxOvf, !dpBusy, rxFull};

  always_comb begin
    busRdata = '0;
    if (inWindow) begin
      unique case (slot)
        SLOT_CFG:  busRdata = WORD_W'(cfgBits);
        SLOT_STAT: busRdata = WORD_W'(statWord);
        SLOT_DATA: busRdata = ring[rdPtr];
        default:   busRdata = WORD_W'(divReg);
      endcase
    end
  end

  assign divider  = divReg;
  assign irqFault = irqF;
  assign irqTx    = irqT;
  assign irqRx    = irqR;

  // R4: disabling silences interrupts and empties the status flags
  a_r4_off_quiets: assert property (@(posedge clk) disable iff (!rstN)
    goingOff |=> (!irqFault && !irqTx && !irqRx && !rxFull && !rxOvf));

  // R3: status writes leave receive-full alone
  a_r3_full_not_writable: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !dpDone && !rdData && !goingOff) |=> (rxFull == $past(rxFull)));

  // R9: a data read drops receive-full when nothing refills it
  a_r9_read_clears_full: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !dpDone && !goingOff) |=> !rxFull);

  // R11: overflow keeps the write pointer and raises the flag
  a_r11_overflow_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dpDone && fullAfterRead && !wrCfg) |=> ((wrPtr == $past(wrPtr)) && rxOvf && irqFault));

  // R10: ring completion steps the write pointer by one
  a_r10_ring_step: assert property (@(posedge clk) disable iff (!rstN)
    (dpDone && ringOn && !fullAfterRead && !wrCfg) |=> (wrPtr == stepPtr($past(wrPtr))));

endmodule

// File: rtl/spi_alias_ctrl.sv
module spi_alias_ctrl
  import spi_alias_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RING_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irqFault,
  output logic        irqTx,
  output logic        irqRx
);

  dpCmd_t             cmd;
  logic [DIV_W-1:0]   divider;
  logic               dpBusy;
  logic               dpDone;
  logic [WORD_W-1:0]  dpRxWord;

  spi_alias_regs #(
    .DIV_W      (DIV_W),
    .RING_DEPTH (RING_DEPTH),
    .ADDR_W     (6)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .dpBusy   (dpBusy),
    .dpDone   (dpDone),
    .dpRxWord (dpRxWord),
    .cmd      (cmd),
    .divider  (divider),
    .irqFault (irqFault),
    .irqTx    (irqTx),
    .irqRx    (irqRx)
  );

  spi_alias_shifter #(
    .DIV_W (DIV_W)
  ) u_shift (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .divider (divider),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (dpBusy),
    .done    (dpDone),
    .rxWord  (dpRxWord)
  );

endmodule

// File: tb/spi_alias_ctrl_bench.sv
module spi_alias_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, mosi, miso;
  logic        irqFault, irqTx, irqRx;

  int compared = 0;
  int mismatched = 0;

  // bench-side SPI slave
  logic [31:0] slaveWord = '0;
  int          slaveBits = 8;
  int          slaveIdx = 0;
  logic [31:0] mosiCap = '0;
  int          sckRises = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = (slaveIdx < slaveBits) ? slaveWord[slaveBits-1-slaveIdx] : 1'b0;

  always @(posedge sck) begin
    mosiCap  = {mosiCap[30:0], mosi};
    sckRises = sckRises + 1;
  end
  always @(negedge sck) slaveIdx = slaveIdx + 1;

  spi_alias_ctrl u_spi_alias_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi), .miso(miso),
    .irqFault(irqFault), .irqTx(irqTx), .irqRx(irqRx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic waitIdle(output int cycles);
    logic [31:0] st;
    cycles = 0;
    for (int k = 0; k < 4000; k++) begin
      busRead(6'd4, st);
      if (!st[3]) break;
      cycles++;
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input logic [31:0] sl, input int nb,
                      output int cycles);
    slaveWord = sl; slaveBits = nb; slaveIdx = 0; mosiCap = '0; sckRises = 0;
    busWrite(6'd8, tx);
    waitIdle(cycles);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R13 reset state
    busRead(6'd0, rd);  check("R13 cfg", rd, 32'h0);
    busRead(6'd4, rd);  check("R13 status", rd, 32'h2);
    busRead(6'd12, rd); check("R13 divider", rd, 32'h0);
    check("R13 irq/sck", {28'b0, irqFault, irqTx, irqRx, sck}, 32'h0);

    // R1 window
    busRead(6'd16, rd); check("R1 above window", rd, 32'h0);
    busRead(6'd63, rd); check("R1 top of range", rd, 32'h0);
    busWrite(6'd28, 32'hFF);
    busRead(6'd12, rd); check("R1 write outside ignored", rd, 32'h0);

    // R2 divider aliases
    busWrite(6'd12, 32'h12);
    busWrite(6'd14, 32'h41); busRead(6'd12, rd); check("R2 div set", rd, 32'h53);
    busWrite(6'd13, 32'h03); busRead(6'd12, rd); check("R2 div clear", rd, 32'h50);
    busWrite(6'd15, 32'hFF); busRead(6'd12, rd); check("R2 div invert", rd, 32'hAF);

    // R2/R4 configuration aliases and width
    busWrite(6'd0, 32'h1);
    busWrite(6'd2, 32'h8); busRead(6'd0, rd); check("R2 cfg set", rd, 32'h9);
    busWrite(6'd3, 32'h6); busRead(6'd0, rd); check("R2 cfg invert", rd, 32'hF);
    busWrite(6'd1, 32'h6); busRead(6'd0, rd); check("R2 cfg clear", rd, 32'h9);
    busWrite(6'd0, 32'hFFFF_FFF0); busRead(6'd0, rd); check("R4 upper cfg bits", rd, 32'h0);

    // R3 status aliases
    busWrite(6'd4, 32'hFFFF_FFFF); busRead(6'd4, rd); check("R3 ovf assign", rd, 32'h6);
    busWrite(6'd5, 32'h4);  busRead(6'd4, rd); check("R3 ovf clear", rd, 32'h2);
    busWrite(6'd7, 32'h4);  busRead(6'd4, rd); check("R3 ovf invert", rd, 32'h6);
    busWrite(6'd6, 32'hB);  busRead(6'd4, rd); check("R3 others ignore", rd, 32'h6);
    busWrite(6'd4, 32'h0);

    // R8 data write ignored while disabled
    sckRises = 0;
    busWrite(6'd8, 32'hFF);
    repeat (10) @(negedge clk);
    check("R8 disabled no sck", sckRises, 0);
    busRead(6'd4, rd); check("R8 disabled status", rd, 32'h2);

    // R6/R7/R9 width and divider sweep in single-slot mode
    for (int w = 0; w < 4; w++) begin
      for (int b = 0; b < 3; b++) begin
        int nb;
        logic [31:0] mask, tx, sl, cfg;
        nb   = (w == 0) ? 8 : (w == 1) ? 16 : 32;
        mask = (nb == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
        cfg  = 32'h1 | ((w == 1 || w == 3) ? 32'h2 : 32'h0) | ((w >= 2) ? 32'h4 : 32'h0);
        tx   = 32'h9E37_79B9 + w * 32'h0101_0101 + b;
        sl   = 32'h6C8E_5A1D ^ (w << 8) ^ b;
        busWrite(6'd0, cfg);
        busWrite(6'd12, b);
        xfer(tx, sl, nb, cyc);
        check("R7 busy cycles", cyc, 2 * nb * (b + 1));
        check("R6 sck edges", sckRises, nb);
        check("R6 mosi bits", mosiCap & mask, tx & mask);
        busRead(6'd4, rd);  check("R9 full after done", rd, 32'h3);
        busRead(6'd8, rd);  check("R6 received word", rd, sl & mask);
        busRead(6'd4, rd);  check("R9 read clears full", rd, 32'h2);
      end
    end

    // R12 / R11 in single-slot mode
    busWrite(6'd0, 32'h0);
    check("R4 off clears irqs", {29'b0, irqFault, irqTx, irqRx}, 32'h0);
    busRead(6'd4, rd); check("R4 off status", rd, 32'h2);
    busWrite(6'd0, 32'h1); busWrite(6'd12, 32'h0);
    xfer(32'h11, 32'hC5, 8, cyc);
    check("R12 irq after fill", {29'b0, irqFault, irqTx, irqRx}, 32'h3);
    xfer(32'h22, 32'h3C, 8, cyc);
    busRead(6'd4, rd); check("R11 overflow status", rd, 32'h7);
    check("R12 fault irq", {31'b0, irqFault}, 32'h1);
    busRead(6'd8, rd); check("R11 newest word kept", rd, 32'h3C);
    busRead(6'd4, rd); check("R11 ovf stays", rd, 32'h6);
    busWrite(6'd0, 32'h0);
    check("R12 sticky cleared by off", {29'b0, irqFault, irqTx, irqRx}, 32'h0);
    busRead(6'd4, rd); check("R4 status after off", rd, 32'h2);

    // R8 data write ignored while busy
    busWrite(6'd0, 32'h1); busWrite(6'd12, 32'h3);
    slaveWord = 32'h0; slaveBits = 8; slaveIdx = 0; mosiCap = '0; sckRises = 0;
    busWrite(6'd8, 32'h5A);
    busWrite(6'd8, 32'hFF);
    busRead(6'd4, rd); check("R8 busy status", rd, 32'h8);
    waitIdle(cyc);
    check("R8 second write ignored", mosiCap & 32'hFF, 32'h5A);
    check("R8 one exchange only", sckRises, 8);
    busRead(6'd8, rd);

    // R10 ring fill, wrap and overflow
    busWrite(6'd12, 32'h0);
    busWrite(6'd0, 32'h1);
    busWrite(6'd0, 32'h9);
    for (int i = 0; i < 3; i++) xfer(32'h0, 32'hA0 + i, 8, cyc);
    busRead(6'd4, rd); check("R10 three entries not full", rd, 32'h2);
    xfer(32'h0, 32'hA3, 8, cyc);
    busRead(6'd4, rd); check("R10 wrap sets full", rd, 32'h3);
    xfer(32'h0, 32'hA4, 8, cyc);
    busRead(6'd4, rd); check("R11 ring overflow", rd, 32'h7);
    busRead(6'd8, rd); check("R11 ring overwrite entry", rd, 32'hA4);
    busRead(6'd4, rd); check("R10 read clears full", rd, 32'h6);
    for (int i = 1; i < 4; i++) begin
      busRead(6'd8, rd); check("R10 ring order", rd, 32'hA0 + i);
    end
    busWrite(6'd5, 32'h4);
    busRead(6'd4, rd); check("R3 ovf cleared", rd, 32'h2);

    // R5 pointer reset when leaving ring mode
    xfer(32'h0, 32'hB0, 8, cyc);
    xfer(32'h0, 32'hB1, 8, cyc);
    busRead(6'd8, rd); check("R10 first ring read", rd, 32'hB0);
    busWrite(6'd0, 32'h1);
    xfer(32'h0, 32'hC0, 8, cyc);
    busRead(6'd8, rd); check("R5 pointers reset", rd, 32'hC0);
    busRead(6'd4, rd); check("R5 status", rd, 32'h2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule